// File: doc/BRIEF.md
# Active-State Rail Sequencer

This block powers the active-state rail group once the chipset has left its deeper sleep levels, and removes that group again when it goes back to sleep. It watches two active-low sleep requests, one for the S4 level and one for the S3 level. When the S4 request is released, it waits for the two memory rails to report good and then raises `s3_ok`. When the S3 request is released, it walks through a fixed bring-up. It waits for the 1.05 V sustain comparator, then enables the load-switch group and then VCCIO. Next it raises the sustain power-good together with the core regulator enable. After that come the system power-ok and finally the chipset power-ok. Each 2 ms gap is a programmable cycle count.

Any wait that runs for the full timeout window aborts the bring-up. The block then tears everything down and parks until the S4 request is asserted again. When the S3 request returns while the block is powering up or fully on, it drops the six outputs one per clock in a strict order and goes back to the S3 level. While fully on, the load-switch group can optionally follow a low-power gate input directly, with no clock delay. This lets the switches open during deep idle without disturbing any power-good.

Top module: `s0_rail_seq`

## Requirements
- R1: After `slp_s4_n` is released, `s3_ok` rises only once `mem25_good` and `mem12_good` are both high. With both already high, it rises on the 4th rising clock edge after the input change: 2 synchronizer stages, 1 decision, 1 register.
- R2: After `slp_s3_n` is released, `s0_rails_en` stays low until `sus_ok` is high. It rises on the first clock edge after `sus_ok` is seen high in that wait.
- R3: `vccio_en` rises exactly `DLY_CYC` clock cycles after `s0_rails_en` rises.
- R4: `sus_pwrgd` and `core_en` rise on the same edge, one cycle after `vccio_good` is seen high. `sys_pwrok` rises exactly `DLY_CYC` cycles after them.
- R5: `chip_pwrok` stays low until `core_rdy` is high. It rises `DLY_CYC+1` cycles after the edge on which `core_rdy` is first seen high after `sys_pwrok`.
- R6: If a wait for `sus_ok`, `vccio_good`, `core_rdy` or the memory goods lasts `TMO_CYC` cycles, every output falls through the ordered teardown of R7. `s3_ok` falls, and the block stays down until `slp_s4_n` goes low.
- R7: When `slp_s3_n` falls during bring-up or while fully on, the teardown removes the outputs one per cycle in a fixed order. Index 0 is `sus_pwrgd`, 1 is `chip_pwrok`, 2 is `sys_pwrok`, 3 is `core_en`, 4 is `s0_rails_en`, 5 is `vccio_en`. Output i falls at edge 3+i after the input change, and any output still low stays low. `s3_ok` stays high.
- R8: While fully on, with `gate_en` high and `slp_s3_n` high, `s0_rails_en` equals `c10_gate_n` combinationally: low means gated. The other five outputs do not change.
- R9: With `gate_en` low, or as soon as `slp_s3_n` is low, `c10_gate_n` has no effect on `s0_rails_en`.
- R10: During and right after reset, every output is low.
- R11: Asserting `slp_s4_n` low while at the S3 level drops `s3_ok` on the 3rd edge after the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slp_s4_n | input | 1 | S4 sleep request, active low |
| slp_s3_n | input | 1 | S3 sleep request, active low |
| c10_gate_n | input | 1 | Low-power gate request, active low |
| gate_en | input | 1 | Allows rail gating from `c10_gate_n` |
| mem25_good | input | 1 | 2.5 V memory rail good |
| mem12_good | input | 1 | 1.2 V memory rail good |
| sus_ok | input | 1 | Comparator flag: 1.05 V sustain rail at or above 1000 mV |
| vccio_good | input | 1 | VCCIO regulator good |
| core_rdy | input | 1 | Core regulator ready |
| s3_ok | output | 1 | S3 level reached (memory rails good) |
| s0_rails_en | output | 1 | Active load-switch group enable |
| vccio_en | output | 1 | VCCIO regulator enable |
| sus_pwrgd | output | 1 | Sustain power-good |
| core_en | output | 1 | Core regulator enable |
| sys_pwrok | output | 1 | System power-ok |
| chip_pwrok | output | 1 | Chipset power-ok |

## Verification
The hardest case to reach is a sleep request that lands in the middle of bring-up. Every step and every delay must be cut short and still give the ordered teardown, with only the outputs already high falling. The bench sweeps the cycle at which `slp_s3_n` falls across the whole bring-up, one run per offset. For each run it checks that each output raised in that run falls exactly at its slot in the teardown order. A second hard case is gating: the test drops the sleep request while the gate input holds the switches open, and checks that the sequencer takes the enable back at once.

// File: rtl/s0_rail_seq.sv
module s0_rail_seq #(
  parameter int DLY_CYC  = 500000,
  parameter int TMO_CYC  = 250000000,
  parameter int SYNC_LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slp_s4_n,
  input  logic slp_s3_n,
  input  logic c10_gate_n,
  input  logic gate_en,
  input  logic mem25_good,
  input  logic mem12_good,
  input  logic sus_ok,
  input  logic vccio_good,
  input  logic core_rdy,
  output logic s3_ok,
  output logic s0_rails_en,
  output logic vccio_en,
  output logic sus_pwrgd,
  output logic core_en,
  output logic sys_pwrok,
  output logic chip_pwrok
);

  localparam int LIM = (TMO_CYC > DLY_CYC) ? TMO_CYC : DLY_CYC;
  localparam int CW  = $clog2(LIM + 1);

  typedef enum logic [3:0] {
    ST_STBY, ST_MEM, ST_S3, ST_SUS, ST_RAIL, ST_VIO,
    ST_SYS, ST_CORE, ST_PWR, ST_ON, ST_DOWN, ST_HOLD
  } st_t;

  st_t st, ret_st;
  logic [SYNC_LEN-1:0] s4_sync, s3_sync;
  logic [CW-1:0] cnt;
  logic [2:0] dstep;
  logic s3_q, s0_q, vio_q, sus_q, core_q, sys_q, chip_q;

  wire s4_s   = s4_sync[SYNC_LEN-1];
  wire s3_s   = s3_sync[SYNC_LEN-1];
  wire tmo    = (cnt == CW'(TMO_CYC - 1));
  wire dly    = (cnt == CW'(DLY_CYC - 1));
  wire upward = (st == ST_SUS) || (st == ST_RAIL) || (st == ST_VIO) || (st == ST_SYS) ||
                (st == ST_CORE) || (st == ST_PWR) || (st == ST_ON);
  wire gating = gate_en && slp_s3_n && (st == ST_ON);

  assign s3_ok       = s3_q;
  assign s0_rails_en = gating ? c10_gate_n : s0_q;
  assign vccio_en    = vio_q;
  assign sus_pwrgd   = sus_q;
  assign core_en     = core_q;
  assign sys_pwrok   = sys_q;
  assign chip_pwrok  = chip_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s4_sync <= '0;
      s3_sync <= '0;
    end else begin
      s4_sync <= {s4_sync[SYNC_LEN-2:0], slp_s4_n};
      s3_sync <= {s3_sync[SYNC_LEN-2:0], slp_s3_n};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_STBY;
      ret_st <= ST_S3;
      cnt    <= '0;
      dstep  <= '0;
      s3_q   <= 1'b0;
      s0_q   <= 1'b0;
      vio_q  <= 1'b0;
      sus_q  <= 1'b0;
      core_q <= 1'b0;
      sys_q  <= 1'b0;
      chip_q <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
      if (upward && !s3_s) begin
        sus_q  <= 1'b0;
        dstep  <= 3'd1;
        ret_st <= ST_S3;
        st     <= ST_DOWN;
      end else begin
        case (st)
          ST_STBY: if (s4_s) begin
            st  <= ST_MEM;
            cnt <= '0;
          end
          ST_MEM: begin
            if (!s4_s) st <= ST_STBY;
            else if (mem25_good && mem12_good) begin
              s3_q <= 1'b1;
              st   <= ST_S3;
            end else if (tmo) st <= ST_HOLD;
          end
          ST_S3: begin
            if (!s4_s) begin
              s3_q <= 1'b0;
              st   <= ST_STBY;
            end else if (s3_s) begin
              st  <= ST_SUS;
              cnt <= '0;
            end
          end
          ST_SUS: begin
            if (sus_ok) begin
              s0_q <= 1'b1;
              st   <= ST_RAIL;
              cnt  <= '0;
            end else if (tmo) begin
              sus_q <= 1'b0; s3_q <= 1'b0; dstep <= 3'd1; ret_st <= ST_HOLD; st <= ST_DOWN;
            end
          end
          ST_RAIL: if (dly) begin
            vio_q <= 1'b1;
            st    <= ST_VIO;
            cnt   <= '0;
          end
          ST_VIO: begin
            if (vccio_good) begin
              sus_q  <= 1'b1;
              core_q <= 1'b1;
              st     <= ST_SYS;
              cnt    <= '0;
            end else if (tmo) begin
              sus_q <= 1'b0; s3_q <= 1'b0; dstep <= 3'd1; ret_st <= ST_HOLD; st <= ST_DOWN;
            end
          end
          ST_SYS: if (dly) begin
            sys_q <= 1'b1;
            st    <= ST_CORE;
            cnt   <= '0;
          end
          ST_CORE: begin
            if (core_rdy) begin
              st  <= ST_PWR;
              cnt <= '0;
            end else if (tmo) begin
              sus_q <= 1'b0; s3_q <= 1'b0; dstep <= 3'd1; ret_st <= ST_HOLD; st <= ST_DOWN;
            end
          end
          ST_PWR: if (dly) begin
            chip_q <= 1'b1;
            st     <= ST_ON;
          end
          ST_DOWN: begin
            dstep <= dstep + 3'd1;
            case (dstep)
              3'd1: chip_q <= 1'b0;
              3'd2: sys_q  <= 1'b0;
              3'd3: core_q <= 1'b0;
              3'd4: s0_q   <= 1'b0;
              default: begin
                vio_q <= 1'b0;
                st    <= ret_st;
              end
            endcase
          end
          ST_HOLD: if (!s4_s) st <= ST_STBY;
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/s0_rail_seq_chk.sv
module s0_rail_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic slp_s3_n,
  input logic c10_gate_n,
  input logic gate_en,
  input logic mem25_good,
  input logic mem12_good,
  input logic s3_ok,
  input logic s0_rails_en,
  input logic vccio_en,
  input logic sus_pwrgd,
  input logic core_en,
  input logic sys_pwrok,
  input logic chip_pwrok
);

  // R1
  s3_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(s3_ok) |-> $past(mem25_good && mem12_good));

  // R4
  sus_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sus_pwrgd) |-> $rose(core_en));

  // R4
  sys_core_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_pwrok |-> core_en);

  // R5
  chip_sys_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chip_pwrok |-> sys_pwrok);

  // R3
  core_vio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_en |-> vccio_en);

  // R7
  chip_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(chip_pwrok) |-> !sus_pwrgd);

  // R8
  gate_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_en && slp_s3_n && sus_pwrgd && chip_pwrok) |-> (s0_rails_en == c10_gate_n));

endmodule

bind s0_rail_seq s0_rail_seq_chk i_chk (.*);

// File: tb/test_s0_rail_seq.sv
module test_s0_rail_seq;
  localparam int D = 5;
  localparam int T = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic slp_s4_n = 0, slp_s3_n = 0, c10_gate_n = 1, gate_en = 0;
  logic mem25_good = 0, mem12_good = 0, sus_ok = 0, vccio_good = 0, core_rdy = 0;
  logic s3_ok, s0_rails_en, vccio_en, sus_pwrgd, core_en, sys_pwrok, chip_pwrok;

  int nchk = 0, nerr = 0, cyc = 0;
  int rise[6], fall[6];
  logic [5:0] prev = '0;
  wire [5:0] outs = {vccio_en, s0_rails_en, core_en, sys_pwrok, chip_pwrok, sus_pwrgd};

  always #2 clk = ~clk;

  s0_rail_seq #(.DLY_CYC(D), .TMO_CYC(T)) i_s0_rail_seq (
    .clk(clk), .rst_n(rst_n), .slp_s4_n(slp_s4_n), .slp_s3_n(slp_s3_n),
    .c10_gate_n(c10_gate_n), .gate_en(gate_en), .mem25_good(mem25_good),
    .mem12_good(mem12_good), .sus_ok(sus_ok), .vccio_good(vccio_good),
    .core_rdy(core_rdy), .s3_ok(s3_ok), .s0_rails_en(s0_rails_en),
    .vccio_en(vccio_en), .sus_pwrgd(sus_pwrgd), .core_en(core_en),
    .sys_pwrok(sys_pwrok), .chip_pwrok(chip_pwrok));

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    #1;
    for (int i = 0; i < 6; i++) begin
      if (outs[i] && !prev[i]) rise[i] = cyc;
      if (!outs[i] && prev[i]) fall[i] = cyc;
    end
    prev = outs;
  end

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitn(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clr();
    for (int i = 0; i < 6; i++) begin
      rise[i] = -1;
      fall[i] = -1;
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    #400000;
    nerr++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    int cd;
    clr();
    waitn(3);
    chk("R10 outs in reset", int'(outs), 0);
    chk("R10 s3_ok in reset", int'(s3_ok), 0);
    rst_n = 1'b1;
    waitn(2);
    chk("R10 outs after reset", int'(outs), 0);

    mem25_good = 1; slp_s4_n = 1;
    waitn(10);
    chk("R1 s3_ok waits for 1.2V mem", int'(s3_ok), 0);
    slp_s4_n = 0;
    waitn(5);
    mem12_good = 1; slp_s4_n = 1;
    waitn(3);
    chk("R1 s3_ok before 4th edge", int'(s3_ok), 0);
    waitn(1);
    chk("R1 s3_ok at 4th edge", int'(s3_ok), 1);
    slp_s4_n = 0;
    waitn(2);
    chk("R11 s3_ok before 3rd edge", int'(s3_ok), 1);
    waitn(1);
    chk("R11 s3_ok after S4 asserted", int'(s3_ok), 0);
    slp_s4_n = 1;
    waitn(4);
    chk("R1 s3_ok again", int'(s3_ok), 1);

    clr();
    vccio_good = 1; slp_s3_n = 1;
    waitn(20);
    chk("R2 s0_rails_en waits for sustain", int'(s0_rails_en), 0);
    chk("R2 vccio_en waits", int'(vccio_en), 0);
    cd = cyc;
    sus_ok = 1;
    waitn(30);
    chk("R2 s0 rise cycle", rise[4], cd + 1);
    chk("R3 vccio spacing", rise[5] - rise[4], D);
    chk("R4 sustain after vccio good", rise[0] - rise[5], 1);
    chk("R4 core with sustain", rise[3], rise[0]);
    chk("R4 sys spacing", rise[2] - rise[0], D);
    chk("R5 chip waits for core ready", int'(chip_pwrok), 0);
    cd = cyc;
    core_rdy = 1;
    waitn(D + 4);
    chk("R5 chip spacing", rise[1], cd + 1 + D);

    gate_en = 0; c10_gate_n = 0;
    #1 chk("R9 gating disabled", int'(s0_rails_en), 1);
    gate_en = 1;
    #1 chk("R8 gated off", int'(s0_rails_en), 0);
    chk("R8 other outputs kept", int'({vccio_en, core_en, sys_pwrok, chip_pwrok, sus_pwrgd}), 31);
    c10_gate_n = 1;
    #1 chk("R8 ungated", int'(s0_rails_en), 1);
    c10_gate_n = 0;
    waitn(1);
    chk("R8 gated again", int'(s0_rails_en), 0);
    clr();
    cd = cyc;
    slp_s3_n = 0;
    #1 chk("R9 sleep takes enable back", int'(s0_rails_en), 1);
    waitn(12);
    for (int i = 0; i < 6; i++) chk($sformatf("R7 gated teardown slot %0d", i), fall[i], cd + 3 + i);
    chk("R7 stays at S3", int'(s3_ok), 1);
    chk("R7 all outputs off", int'(outs), 0);
    gate_en = 0; c10_gate_n = 1;

    for (int k = 0; k <= 3 * D + 8; k++) begin
      clr();
      slp_s3_n = 1;
      waitn(k);
      cd = cyc;
      slp_s3_n = 0;
      waitn(14);
      chk($sformatf("R7 sweep %0d outputs off", k), int'(outs), 0);
      chk($sformatf("R7 sweep %0d s3_ok", k), int'(s3_ok), 1);
      for (int i = 0; i < 6; i++)
        if (rise[i] != -1)
          chk($sformatf("R7 sweep %0d slot %0d", k, i), fall[i], cd + 3 + i);
    end

    clr();
    vccio_good = 0;
    cd = cyc;
    slp_s3_n = 1;
    waitn(4 + D + T + 10);
    chk("R6 timeout vccio fall", fall[5], cd + 9 + D + T);
    chk("R6 s0 fall", fall[4], cd + 8 + D + T);
    chk("R6 s3_ok dropped", int'(s3_ok), 0);
    waitn(10);
    chk("R6 held down", int'(outs), 0);
    chk("R6 s3_ok held", int'(s3_ok), 0);
    slp_s3_n = 0; slp_s4_n = 0;
    waitn(5);
    vccio_good = 1; slp_s4_n = 1;
    waitn(4);
    chk("R6 recovers after S4", int'(s3_ok), 1);

    finish_run();
  end
endmodule